// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Controller

This block sits between a 32-bit register port and a serial word engine. Software writes transmit words into an 8-entry transmit FIFO and reads received words out of an 8-entry receive FIFO. Both FIFOs use a single data offset: a write there pushes the transmit FIFO, and a read there pops the receive FIFO. The engine that does the shifting and generates the clock is outside the block. It is reached through a simple exchange. The block hands over one transmit word with a start pulse. Some cycles later the engine returns one received word with a done pulse.

A FIFO control register holds a threshold for each FIFO and a self-clearing flush bit for each FIFO. The block raises three sticky interrupt flags:
- receive-reached-threshold;
- receive overrun, when a word arrives while the receive FIFO is full;
- transmit low-water.

Each flag has its own enable, and software clears a flag by writing 1 to its bit at the offset where the flags are read. The level interrupt output is high while any enabled flag is set.

Top module: `sfq_ctrl`

## Requirements
- R1: Each FIFO holds 8 words. A write to the data offset while the transmit FIFO holds 8 words is dropped, and neither FIFO count ever exceeds 8.
- R2: Register offsets are 0x00 control, 0x08 FIFO control, 0x0C status, 0x10 interrupt enable, 0x14 interrupt status/clear and 0x18 data. A write to 0x18 appends to the transmit FIFO. A read of 0x18 returns the oldest received word and removes it, and the read returns 0 when the receive FIFO is empty.
- R3: `eng_start` pulses only while control bit 0 (enable) is 1 and the transmit FIFO is non-empty. It presents the oldest transmit word on `eng_txd` and removes that word. No new start is issued until `eng_done` returns, so at most one word is in flight.
- R4: Status bit 0 reads 1 exactly while the receive FIFO is non-empty.
- R5: In the FIFO control register, bits 11:8 hold the transmit threshold and bits 3:0 hold the receive threshold, and both read back as written. Writing 1 to bit 12 empties the transmit FIFO, and writing 1 to bit 4 empties the receive FIFO, each within the write cycle. Bits 12 and 4 always read 0.
- R6: Interrupt status bit 9 (receive-ready) is live and reads 1 while the receive count is at or above the receive threshold. It reads 1 after reset, because the threshold resets to 0.
- R7: Interrupt status bit 3 (receive-complete) latches one cycle after receive-ready goes from 0 to 1, and it stays set until software clears it.
- R8: Interrupt status bit 0 (overrun) latches when the engine returns a word while the receive FIFO is full. That word is discarded, and the flag is sticky.
- R9: Interrupt status bit 4 (transmit low-water) latches when the transmit count falls from above the transmit threshold to at or below it.
- R10: Writing 1 to bit 4, 3 or 0 at offset 0x14 clears the matching flag, and writing 0 to a bit leaves that flag unchanged. If a flag is set and cleared in the same cycle, it stays set.
- R11: The interrupt enable register bits 4, 3 and 0 gate the flags in the same positions. `irq` is the OR of each flag ANDed with its enable.
- R12: After reset the control, FIFO control, status and enable registers read 0, interrupt status reads 0x200, data reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive FIFO at the data offset) |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from offset |
| eng_start | output | 1 | One-cycle request for the engine to send `eng_txd` |
| eng_txd | output | DATA_W | Word handed to the engine |
| eng_done | input | 1 | Engine returns a received word |
| eng_rxd | input | DATA_W | Received word |
| irq | output | 1 | Level interrupt |

## Verification
If a FIFO pointer or count goes wrong, the error shows up on the first data read after it. A word comes back out of order, duplicated or missing, and status bit 0 disagrees with the number of words written. A flag that latches at the wrong moment, or fails to hold, is visible one cycle after its event in the interrupt status read and on `irq`. A wrong gating of `eng_start` shows as engine starts while the controller is disabled, or as words arriving in the receive FIFO when the transmit FIFO was flushed. The stimulus covers several word counts against several receive thresholds, a full receive FIFO followed by one extra word, and flushes.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    // Register byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_FCTL = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_IEN  = 8'h10;
    localparam logic [7:0] OFF_IST  = 8'h14;
    localparam logic [7:0] OFF_DATA = 8'h18;

    // Bit positions
    localparam int B_TX_FLUSH = 12;
    localparam int B_RX_FLUSH = 4;
    localparam int B_READY    = 9;
    localparam int B_TXLW     = 4;
    localparam int B_RC       = 3;
    localparam int B_OVR      = 0;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_FCTL, SEL_STAT, SEL_IEN, SEL_IST, SEL_DATA, SEL_NONE
    } sel_e;

    typedef struct packed {
        logic [3:0] tx;
        logic [3:0] rx;
    } thr_t;

    // vector order: [2] tx low-water, [1] receive-complete, [0] overrun
    typedef struct packed {
        logic txlw;
        logic rc;
        logic ovr;
    } flags_t;

    function automatic sel_e decode(input logic [7:0] a);
        case (a)
            OFF_CTRL: return SEL_CTRL;
            OFF_FCTL: return SEL_FCTL;
            OFF_STAT: return SEL_STAT;
            OFF_IEN:  return SEL_IEN;
            OFF_IST:  return SEL_IST;
            OFF_DATA: return SEL_DATA;
            default:  return SEL_NONE;
        endcase
    endfunction

    // pick the three flag-position bits out of a written word
    function automatic logic [2:0] flag_bits(input logic [31:0] w);
        return {w[B_TXLW], w[B_RC], w[B_OVR]};
    endfunction

    function automatic logic [31:0] pack_flags(input flags_t f, input logic rdy);
        logic [31:0] v;
        v = '0;
        v[B_READY] = rdy;
        v[B_TXLW]  = f.txlw;
        v[B_RC]    = f.rc;
        v[B_OVR]   = f.ovr;
        return v;
    endfunction
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             acc_push, acc_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign acc_push = push && !full;
    assign acc_pop  = pop && !empty;
    assign head     = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (acc_push) wp <= step(wp);
            if (acc_pop)  rp <= step(rp);
            count <= count + CNT_W'(acc_push) - CNT_W'(acc_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (acc_push && !flush && !rst) mem[wp] <= din;
    end
endmodule

// File: rtl/sfq_flags.sv
module sfq_flags
    import sfq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  thr_t             thr,
    input  logic             ovr_evt,
    input  logic [2:0]       clr,
    input  logic [2:0]       en,
    output flags_t           flags,
    output logic             rx_ready,
    output logic             irq
);
    logic       ready_q, above_q, tx_above;
    logic [2:0] set, fv;

    assign rx_ready = 32'(rx_cnt) >= 32'(thr.rx);
    assign tx_above = 32'(tx_cnt) > 32'(thr.tx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b1;
            above_q <= 1'b0;
        end else begin
            ready_q <= rx_ready;
            above_q <= tx_above;
        end
    end

    assign set = {above_q & ~tx_above, rx_ready & ~ready_q, ovr_evt};

    for (genvar g = 0; g < 3; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) fv[g] <= 1'b0;
            else     fv[g] <= set[g] | (fv[g] & ~clr[g]);
        end
    end

    assign flags = flags_t'(fv);
    assign irq   = |(fv & en);
endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_txd,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rxd,
    output logic              irq
);
    sel_e             sel;
    logic             ctrl_en, busy;
    thr_t             thr;
    logic [2:0]       ien, clr;
    logic             tx_push, tx_flush, rx_pop, rx_flush;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    flags_t           flg;
    logic             rx_ready, ovr_evt;

    assign sel      = decode(reg_addr);
    assign tx_push  = reg_wr && sel == SEL_DATA;
    assign tx_flush = reg_wr && sel == SEL_FCTL && reg_wdata[B_TX_FLUSH];
    assign rx_flush = reg_wr && sel == SEL_FCTL && reg_wdata[B_RX_FLUSH];
    assign rx_pop   = reg_rd && sel == SEL_DATA;
    assign clr      = (reg_wr && sel == SEL_IST) ? flag_bits(32'(reg_wdata)) : 3'b000;
    assign eng_start = ctrl_en && !tx_empty && !busy;
    assign ovr_evt  = eng_done && rx_full && !rx_flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            thr     <= '0;
            ien     <= '0;
            busy    <= 1'b0;
        end else begin
            if (reg_wr && sel == SEL_CTRL) ctrl_en <= reg_wdata[0];
            if (reg_wr && sel == SEL_FCTL) thr <= {reg_wdata[11:8], reg_wdata[3:0]};
            if (reg_wr && sel == SEL_IEN)  ien <= flag_bits(32'(reg_wdata));
            if (eng_start)     busy <= 1'b1;
            else if (eng_done) busy <= 1'b0;
        end
    end

    sfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata), .pop(eng_start),
        .flush(tx_flush), .head(eng_txd), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(eng_done), .din(eng_rxd), .pop(rx_pop),
        .flush(rx_flush), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    sfq_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst(rst), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .thr(thr),
        .ovr_evt(ovr_evt), .clr(clr), .en(ien), .flags(flg), .rx_ready(rx_ready), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: reg_rdata[0] = ctrl_en;
            SEL_FCTL: reg_rdata = DATA_W'({20'h0, thr.tx, 4'h0, thr.rx});
            SEL_STAT: reg_rdata[0] = !rx_empty;
            SEL_IEN:  reg_rdata = DATA_W'(pack_flags(flags_t'(ien), 1'b0));
            SEL_IST:  reg_rdata = DATA_W'(pack_flags(flg, rx_ready));
            SEL_DATA: reg_rdata = rx_empty ? '0 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfq_ctrl_chk.sv
module sfq_ctrl_chk
    import sfq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              eng_start,
    input logic              eng_done,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input flags_t            flg,
    input logic              rx_ready
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH)); // R1

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        eng_start && !eng_done |=> !eng_start); // R3

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == OFF_FCTL && reg_wdata[B_RX_FLUSH] |=> rx_cnt == '0); // R5

    AST_RC_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |=> flg.rc); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        flg.ovr && !(reg_wr && reg_addr == OFF_IST && reg_wdata[B_OVR]) |=> flg.ovr); // R8
endmodule

bind sfq_ctrl sfq_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .eng_start(eng_start), .eng_done(eng_done), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .flg(flg), .rx_ready(rx_ready)
);

// File: tb/sfq_ctrl_bench.sv
`timescale 1ns/1ps
module sfq_ctrl_bench;
    localparam logic [31:0] MASK = 32'hFFFF_0000;
    localparam logic [7:0] A_CTRL = 8'h00, A_FCTL = 8'h08, A_STAT = 8'h0C,
                           A_IEN = 8'h10, A_IST = 8'h14, A_DATA = 8'h18;
    // {word count, receive threshold}
    localparam logic [7:0] VEC [6] = '{8'h11, 8'h32, 8'h45, 8'h88, 8'h20, 8'h63};

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, eng_txd, eng_rxd = 0;
    logic        eng_start, eng_done = 0, irq;
    int nchk = 0, nerr = 0, starts = 0, dly = 0;
    logic [31:0] hold = 0, v;

    always #4 clk = ~clk;

    sfq_ctrl u_sfq_ctrl (.*);

    // engine model: 3-cycle exchange, returns transmit word XOR MASK
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (rst) dly <= 0;
        else if (eng_start) begin
            hold <= eng_txd; dly <= 3; starts <= starts + 1;
        end else if (dly > 0) begin
            dly <= dly - 1;
            if (dly == 1) begin eng_done <= 1'b1; eng_rxd <= hold ^ MASK; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int s0;
        idle(4); rst = 0; idle(1);

        // R12 reset state
        #1 chk("R12 irq", {31'b0, irq}, 0);
        rd(A_CTRL, v); chk("R12 ctrl", v, 0);
        rd(A_FCTL, v); chk("R12 fctl", v, 0);
        rd(A_STAT, v); chk("R12 stat", v, 0);
        rd(A_IEN, v);  chk("R12 ien", v, 0);
        rd(A_IST, v);  chk("R12 ist", v, 32'h200);
        rd(A_DATA, v); chk("R12 data", v, 0);

        // table walk: R2 R4 R6 R7 R9
        foreach (VEC[k]) begin
            int n, t;
            n = int'(VEC[k][7:4]); t = int'(VEC[k][3:0]);
            wr(A_CTRL, 0);
            wr(A_FCTL, 32'h1010 | t);
            idle(3);
            wr(A_IST, 32'h19);
            for (int i = 0; i < n; i++) wr(A_DATA, {8'(k), 8'h5A, 16'(i * 257)});
            wr(A_CTRL, 1);
            idle(80);
            wr(A_CTRL, 0);
            rd(A_STAT, v); chk("R4 rx not empty", v, 1);
            rd(A_IST, v);
            chk("R6 R7 R9 flags", v, ((n >= t) ? 32'h200 : 0) | ((t > 0 && n >= t) ? 32'h8 : 0) | 32'h10);
            for (int i = 0; i < n; i++) begin
                rd(A_DATA, v); chk("R2 order", v, {8'(k), 8'h5A, 16'(i * 257)} ^ MASK);
            end
            rd(A_STAT, v); chk("R4 empty after reads", v, 0);
            rd(A_DATA, v); chk("R2 empty read", v, 0);
        end

        // R3: disabled controller never starts the engine
        wr(A_FCTL, 32'h1010); idle(3); wr(A_IST, 32'h19);
        s0 = starts;
        wr(A_DATA, 32'h1111_0001); wr(A_DATA, 32'h1111_0002);
        idle(40);
        chk("R3 no start while disabled", 32'(starts - s0), 0);
        rd(A_STAT, v); chk("R3 rx empty while disabled", v, 0);
        wr(A_CTRL, 1); idle(40);
        chk("R3 starts once enabled", 32'(starts - s0), 2);
        rd(A_DATA, v); chk("R3 word 1", v, 32'h1111_0001 ^ MASK);
        rd(A_DATA, v); chk("R3 word 2", v, 32'h1111_0002 ^ MASK);

        // R5: flush and readback
        wr(A_DATA, 32'h2222_0001); idle(20);
        rd(A_STAT, v); chk("R5 rx filled", v, 1);
        wr(A_CTRL, 0);
        wr(A_DATA, 32'h2222_0002); wr(A_DATA, 32'h2222_0003);
        s0 = starts;
        wr(A_FCTL, 32'h1317);
        rd(A_FCTL, v); chk("R5 readback", v, 32'h0307);
        rd(A_STAT, v); chk("R5 rx flushed", v, 0);
        wr(A_CTRL, 1); idle(30);
        chk("R5 tx flushed", 32'(starts - s0), 0);

        // R1 R8 R10 R11: overrun
        wr(A_CTRL, 0); wr(A_FCTL, 32'h1010); idle(3); wr(A_IST, 32'h19);
        for (int i = 0; i < 9; i++) wr(A_DATA, 32'hC0DE_0000 + i);
        wr(A_CTRL, 1); idle(100);
        rd(A_IST, v); chk("R1 R8 eight words, no overrun", v, 32'h210);
        wr(A_DATA, 32'hDEAD_0009); idle(20);
        rd(A_IST, v); chk("R8 overrun set", v & 32'h1, 1);
        #1 chk("R11 irq masked", {31'b0, irq}, 0);
        wr(A_IEN, 32'h1);
        #1 chk("R11 irq overrun", {31'b0, irq}, 1);
        for (int i = 0; i < 8; i++) begin
            rd(A_DATA, v); chk("R1 R8 kept words", v, (32'hC0DE_0000 + i) ^ MASK);
        end
        rd(A_STAT, v); chk("R1 ninth word dropped", v, 0);
        rd(A_IST, v); chk("R8 sticky", v & 32'h1, 1);
        wr(A_IST, 32'h18);
        rd(A_IST, v); chk("R10 zero bit keeps overrun", v & 32'h1, 1);
        wr(A_IST, 32'h1);
        rd(A_IST, v); chk("R10 overrun cleared", v & 32'h1, 0);
        #1 chk("R11 irq drops", {31'b0, irq}, 0);

        // R7 R11: receive-complete interrupt
        wr(A_IEN, 32'h8); wr(A_FCTL, 32'h1012); idle(3); wr(A_IST, 32'h19);
        wr(A_DATA, 32'h3333_0001); idle(20);
        #1 chk("R7 below threshold no irq", {31'b0, irq}, 0);
        wr(A_DATA, 32'h3333_0002); idle(20);
        #1 chk("R7 R11 irq at threshold", {31'b0, irq}, 1);
        wr(A_IST, 32'h8);
        #1 chk("R10 rc cleared", {31'b0, irq}, 0);

        finish_run();
    end
endmodule